// File: doc/BRIEF.md
# I2C memory transaction sequencer

This block sits between a command source and an I2C bit engine. It turns one memory-style command into the ordered list of bus operations (start, stop, byte write, byte read) that the bit engine carries out. The bit engine owns all bus timing. This block only chooses the next operation and reacts to the acknowledge each byte returns.

Three commands are supported: probe, read and write. A probe checks whether a device answers at a 7-bit address. A read first sets the target's internal pointer with 0 to 4 address bytes, turns the bus around, and then streams bytes out through a valid/ready port. A write sends the address bytes and then a burst of bytes taken from a valid/ready port. A NACK on a written data byte is counted rather than ending the burst. For memories that spread extra address bits over several device addresses, a parameter mask folds the address bits above the sent bytes into the low bits of the device address.

Top module: `i2c_mem_seq`

## Requirements
- R1: After reset `busy`, `error`, `present`, `fail_count`, `be_req`, `rd_valid` and `wr_ready` are 0, and `cmd_ready` is 1.
- R2: Bit-engine operations are coded on `be_op` as 0 start, 1 stop, 2 byte write (byte on `be_byte`), 3 byte read (`be_rd_nack`=1 sends a NACK). `be_req` and these fields are held stable until `be_done`. On `be_done`, `be_nack`=1 means the written byte was not acknowledged and `be_rdata` holds the byte that was read.
- R3: `cmd_op` selects 1 read, 2 write, and 0 or 3 probe. A probe issues start, write of {`cmd_dev`,0}, stop, with no address folding. `present` becomes 1 if that byte was acknowledged and 0 if it was not, and `error` stays 0.
- R4: Exactly `cmd_alen` (0 to 4) internal address bytes are written, most significant byte first.
- R5: A read with `cmd_alen`>0 issues start, write {dev,0}, the address bytes, then a turnaround: stop then start when `cfg_rep_start`=0, or start alone when it is 1. The turnaround is followed by write {dev,1}.
- R6: A read with `cmd_alen`=0 issues start and then write {dev,1} directly.
- R7: A read of `cmd_len` bytes issues that many byte reads. `be_rd_nack` is 1 only on the last one, and a stop follows. Each byte is offered on `rd_data` with `rd_valid` held until `rd_ready`, and the bytes arrive in bus order.
- R8: For reads and writes, the device address sent is `cmd_dev` OR ((`cmd_addr` >> 8·`cmd_alen`) AND `OVF_MASK`), taking the low 7 bits.
- R9: A NACK of {dev,0} during a read or write ends the command with a stop and sets `error` to 1.
- R10: A NACK of an internal address byte ends the command with a stop and sets `error` to 1.
- R11: During a write, each NACKed data byte adds 1 to `fail_count`. The burst continues, a stop ends it, and `error` stays 0.
- R12: The acknowledge of {dev,1} has no effect. The reads proceed and `error` stays 0.
- R13: `busy` is 1 from the cycle after a command is accepted until the final stop completes. `cmd_ready` is the inverse of `busy`. `error`, `present` and `fail_count` clear on accept and hold their value after the command until the next accept.
- R14: Write data is taken one byte per transfer on `wr_valid`/`wr_ready`, in order, only when the next byte is due, and stalls on the source side delay the burst without changing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 1 read, 2 write, 0/3 probe |
| cmd_dev | input | 7 | Device address |
| cmd_addr | input | 8·ADDR_BYTES | Internal address |
| cmd_alen | input | ALEN_W | Number of internal address bytes |
| cmd_len | input | LEN_W | Number of data bytes |
| cfg_rep_start | input | 1 | 1 repeated start, 0 stop then start at read turnaround |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte wanted |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| be_req | output | 1 | Bit-engine operation requested |
| be_op | output | 2 | Bit-engine operation code |
| be_byte | output | 8 | Byte to write |
| be_rd_nack | output | 1 | Send NACK after this read |
| be_done | input | 1 | Operation complete (one cycle) |
| be_nack | input | 1 | Written byte not acknowledged |
| be_rdata | input | 8 | Byte read from the bus |
| busy | output | 1 | Command in progress |
| error | output | 1 | Device or address byte not acknowledged |
| present | output | 1 | Probe result |
| fail_count | output | LEN_W | NACKed data bytes of the last write |

## Verification
The bench builds the block with `OVF_MASK` = 3, four address bytes and 8-bit lengths. With these values one- and two-byte addresses carry bits that fold into the device address, and a four-byte address shifts everything out so that nothing folds. The bit engine in the bench answers each operation after a short delay, using a scripted acknowledge pattern. This covers NACKs on the device, address and data bytes, an ignored NACK on the read-direction address, and both turnaround settings. Both data ports stall on fixed patterns, so the bench exercises hold behaviour at the byte handshakes.

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq #(
  parameter int          ADDR_BYTES = 4,
  parameter int          LEN_W      = 8,
  parameter logic [6:0]  OVF_MASK   = 7'h00,
  localparam int         ADDR_W     = 8 * ADDR_BYTES,
  localparam int         ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [6:0]        cmd_dev,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ALEN_W-1:0] cmd_alen,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cfg_rep_start,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              be_req,
  output logic [1:0]        be_op,
  output logic [7:0]        be_byte,
  output logic              be_rd_nack,
  input  logic              be_done,
  input  logic              be_nack,
  input  logic [7:0]        be_rdata,
  output logic              busy,
  output logic              error,
  output logic              present,
  output logic [LEN_W-1:0]  fail_count
);

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_STOP  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;
  localparam logic [1:0] OP_READ  = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DEVW, S_ADDR, S_TSTOP, S_DEVR,
    S_RD, S_RHOLD, S_WGET, S_WR, S_STOP
  } st_t;

  st_t               st;
  logic [1:0]        op_q;
  logic [6:0]        dev_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ALEN_W-1:0] acnt;
  logic [LEN_W-1:0]  lcnt;
  logic              rep_q;
  logic              rdir;
  logic [7:0]        buf_q;

  wire is_rd = (op_q == 2'd1);
  wire is_wr = (op_q == 2'd2);
  wire last  = (lcnt == LEN_W'(1));
  wire fin   = be_req && be_done;

  wire [6:0] hi7      = 7'({8'd0, cmd_addr} >> {cmd_alen, 3'b000});
  wire       mem_cmd  = (cmd_op == 2'd1) || (cmd_op == 2'd2);
  wire [6:0] fold_dev = mem_cmd ? (cmd_dev | (hi7 & OVF_MASK)) : cmd_dev;
  wire [7:0] abyte    = 8'(addr_q >> {acnt - ALEN_W'(1), 3'b000});

  assign busy      = (st != S_IDLE);
  assign cmd_ready = !busy;
  assign rd_valid  = (st == S_RHOLD);
  assign rd_data   = buf_q;
  assign wr_ready  = (st == S_WGET);
  assign be_req    = st inside {S_START, S_DEVW, S_ADDR, S_TSTOP, S_DEVR, S_RD, S_WR, S_STOP};
  assign be_rd_nack = (st == S_RD) && last;

  always_comb begin
    be_op   = OP_START;
    be_byte = 8'h00;
    case (st)
      S_TSTOP, S_STOP: be_op = OP_STOP;
      S_DEVW: begin be_op = OP_WRITE; be_byte = {dev_q, 1'b0}; end
      S_ADDR: begin be_op = OP_WRITE; be_byte = abyte; end
      S_DEVR: begin be_op = OP_WRITE; be_byte = {dev_q, 1'b1}; end
      S_WR:   begin be_op = OP_WRITE; be_byte = buf_q; end
      S_RD:   be_op = OP_READ;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      op_q       <= 2'd0;
      dev_q      <= 7'd0;
      addr_q     <= '0;
      acnt       <= '0;
      lcnt       <= '0;
      rep_q      <= 1'b0;
      rdir       <= 1'b0;
      buf_q      <= 8'h00;
      error      <= 1'b0;
      present    <= 1'b0;
      fail_count <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q       <= cmd_op;
          dev_q      <= fold_dev;
          addr_q     <= cmd_addr;
          acnt       <= cmd_alen;
          lcnt       <= cmd_len;
          rep_q      <= cfg_rep_start;
          rdir       <= (cmd_op == 2'd1) && (cmd_alen == '0);
          error      <= 1'b0;
          present    <= 1'b0;
          fail_count <= '0;
          st         <= S_START;
        end
        S_START: if (fin) st <= rdir ? S_DEVR : S_DEVW;
        S_DEVW: if (fin) begin
          if (!is_rd && !is_wr) begin
            present <= !be_nack;
            st      <= S_STOP;
          end else if (be_nack) begin
            error <= 1'b1;
            st    <= S_STOP;
          end else if (acnt != '0) begin
            st <= S_ADDR;
          end else begin
            st <= (lcnt == '0) ? S_STOP : S_WGET;
          end
        end
        S_ADDR: if (fin) begin
          if (be_nack) begin
            error <= 1'b1;
            st    <= S_STOP;
          end else begin
            acnt <= acnt - ALEN_W'(1);
            if (acnt == ALEN_W'(1)) begin
              if (is_rd) begin
                rdir <= 1'b1;
                st   <= rep_q ? S_START : S_TSTOP;
              end else begin
                st <= (lcnt == '0) ? S_STOP : S_WGET;
              end
            end
          end
        end
        S_TSTOP: if (fin) st <= S_START;
        S_DEVR: if (fin) st <= (lcnt == '0) ? S_STOP : S_RD;
        S_RD: if (fin) begin
          buf_q <= be_rdata;
          st    <= S_RHOLD;
        end
        S_RHOLD: if (rd_ready) begin
          lcnt <= lcnt - LEN_W'(1);
          st   <= last ? S_STOP : S_RD;
        end
        S_WGET: if (wr_valid) begin
          buf_q <= wr_data;
          st    <= S_WR;
        end
        S_WR: if (fin) begin
          if (be_nack) fail_count <= fail_count + LEN_W'(1);
          lcnt <= lcnt - LEN_W'(1);
          st   <= last ? S_STOP : S_WGET;
        end
        S_STOP: if (fin) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: an open request keeps its operation until the engine finishes it
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && !be_done |=> be_req && $stable(be_op) && $stable(be_byte) && $stable(be_rd_nack));

  // R13: the command ends only on a completed stop
  a_r13_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(be_done && be_op == OP_STOP));

  // R13: accept starts a command with cleared results
  a_r13_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy && !error && !present && fail_count == '0);

  // R11: the failure count moves by one and only on a NACK
  a_r11_fail_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy && fail_count != $past(fail_count)
      |-> fail_count == $past(fail_count) + LEN_W'(1) && $past(be_done && be_nack));

  // R9 / R10: error rises only after a NACK from the engine
  a_r9_error_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(be_done && be_nack));

  // R7: a read byte stays on offer until taken
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

endmodule

// File: tb/i2c_mem_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_seq_tb_top;
  localparam int ENG_DLY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [6:0]  cmd_dev = 7'd0;
  logic [31:0] cmd_addr = 32'd0;
  logic [2:0]  cmd_alen = 3'd0;
  logic [7:0]  cmd_len = 8'd0;
  logic        cfg_rep_start = 1'b0;
  logic        wr_valid, wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid, rd_ready;
  logic [7:0]  rd_data;
  logic        be_req, be_rd_nack, be_done, be_nack;
  logic [1:0]  be_op;
  logic [7:0]  be_byte, be_rdata;
  logic        busy, error, present;
  logic [7:0]  fail_count;

  i2c_mem_seq #(.ADDR_BYTES(4), .LEN_W(8), .OVF_MASK(7'h03)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_dev(cmd_dev),
    .cmd_addr(cmd_addr), .cmd_alen(cmd_alen), .cmd_len(cmd_len), .cfg_rep_start(cfg_rep_start),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .be_req(be_req), .be_op(be_op), .be_byte(be_byte), .be_rd_nack(be_rd_nack),
    .be_done(be_done), .be_nack(be_nack), .be_rdata(be_rdata),
    .busy(busy), .error(error), .present(present), .fail_count(fail_count)
  );

  int checks = 0;
  int errors = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];
  logic [8:0]  resp_q[$];
  logic [7:0]  wq[$];
  logic [7:0]  rexp_q[$];
  logic [7:0]  got_q[$];

  function automatic void chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  function automatic void want(logic [1:0] op, logic [7:0] b, bit f, string tag);
    exp_q.push_back({op, b, f});
    tag_q.push_back(tag);
  endfunction

  function automatic void resp(bit n, logic [7:0] d);
    resp_q.push_back({n, d});
  endfunction

  function automatic logic [6:0] fold(logic [6:0] dev, logic [31:0] addr, int alen);
    longint unsigned x;
    x = {32'd0, addr};
    x = x >> (8 * alen);
    return dev | (x[6:0] & 7'h03);
  endfunction

  // behavioural bit engine: compares every requested operation with the model queue
  initial begin
    be_done = 1'b0; be_nack = 1'b0; be_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n && be_req) begin
        logic [10:0] it;
        logic [10:0] e;
        logic [8:0]  r;
        string       t;
        it = {be_op, (be_op == 2'd2) ? be_byte : 8'h00, (be_op == 2'd3) ? be_rd_nack : 1'b0};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected bus op", longint'(it), 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(it == e, t, "bus op {op,byte,nack}", longint'(it), longint'(e));
        end
        if (be_op >= 2'd2) begin
          r = (resp_q.size() > 0) ? resp_q.pop_front() : 9'h100;
          be_nack  = r[8];
          be_rdata = r[7:0];
        end
        repeat (ENG_DLY) @(negedge clk);
        be_done = 1'b1;
        @(negedge clk);
        be_done = 1'b0;
        be_nack = 1'b0;
      end
    end
  end

  // write source with a stall pattern (R14)
  initial begin
    int n;
    n = 0;
    wr_valid = 1'b0; wr_data = 8'h00;
    forever begin
      @(negedge clk);
      n++;
      if (wr_ready && wq.size() > 0 && (n % 3) != 0) begin
        wr_valid = 1'b1;
        wr_data  = wq.pop_front();
      end else begin
        wr_valid = 1'b0;
      end
    end
  end

  // read sink with a stall pattern (R7)
  initial begin
    int n;
    n = 0;
    rd_ready = 1'b0;
    forever begin
      @(negedge clk);
      n++;
      rd_ready = (n % 4) != 1;
      if (rd_valid && rd_ready) got_q.push_back(rd_data);
    end
  end

  task automatic issue(logic [1:0] op, logic [6:0] dev, logic [31:0] addr, int alen, int len, bit rep);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R13", "cmd_ready while idle", cmd_ready, 1);
    cmd_op = op; cmd_dev = dev; cmd_addr = addr; cmd_alen = 3'(alen);
    cmd_len = 8'(len); cfg_rep_start = rep; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1 && cmd_ready == 1'b0, "R13", "busy after accept", busy, 1);
    while (busy) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "ops left unissued", exp_q.size(), 0);
    exp_q.delete(); tag_q.delete(); resp_q.delete();
  endtask

  task automatic finish_checks(bit e_err, bit e_pres, int e_fail, string tag);
    chk(error == e_err, tag, "error", error, e_err);
    chk(present == e_pres, tag, "present", present, e_pres);
    chk(fail_count == 8'(e_fail), tag, "fail_count", fail_count, e_fail);
    chk(got_q.size() == rexp_q.size(), "R7", "read byte count", got_q.size(), rexp_q.size());
    while (got_q.size() > 0 && rexp_q.size() > 0) begin
      logic [7:0] g;
      logic [7:0] x;
      g = got_q.pop_front();
      x = rexp_q.pop_front();
      chk(g == x, "R7", "read byte", g, x);
    end
    got_q.delete(); rexp_q.delete();
    chk(wq.size() == 0, "R14", "write bytes left", wq.size(), 0);
    repeat (6) @(negedge clk);
    chk(error == e_err && present == e_pres && fail_count == 8'(e_fail) && !busy,
        "R13", "results held while idle", {error, present, fail_count}, {e_err, e_pres, 8'(e_fail)});
  endtask

  task automatic do_probe(logic [1:0] op, logic [6:0] dev, bit nack);
    want(2'd0, 8'h00, 1'b0, "R3");
    want(2'd2, {dev, 1'b0}, 1'b0, "R3");
    resp(nack, 8'h00);
    want(2'd1, 8'h00, 1'b0, "R3");
    issue(op, dev, 32'h0000_00FF, 0, 0, 1'b0);
    finish_checks(1'b0, !nack, 0, "R3");
  endtask

  task automatic do_read(logic [6:0] dev, logic [31:0] addr, int alen, int len, bit rep,
                         bit devnack, int anack, bit rdevnack, logic [7:0] seed, string tag);
    logic [6:0] fd;
    bit         ab;
    fd = fold(dev, addr, alen);
    ab = 1'b0;
    want(2'd0, 8'h00, 1'b0, tag);
    if (alen > 0) begin
      want(2'd2, {fd, 1'b0}, 1'b0, "R8");
      resp(devnack, 8'h00);
      if (devnack) ab = 1'b1;
      for (int i = alen - 1; i >= 0 && !ab; i--) begin
        want(2'd2, 8'(addr >> (8 * i)), 1'b0, "R4");
        resp(i == anack, 8'h00);
        if (i == anack) ab = 1'b1;
      end
      if (!ab) begin
        if (!rep) want(2'd1, 8'h00, 1'b0, "R5");
        want(2'd0, 8'h00, 1'b0, "R5");
      end
    end
    if (!ab) begin
      want(2'd2, {fd, 1'b1}, 1'b0, (alen == 0) ? "R6" : "R5");
      resp(rdevnack, 8'h00);
      for (int k = 0; k < len; k++) begin
        logic [7:0] d;
        d = seed + 8'(k * 37);
        want(2'd3, 8'h00, k == len - 1, "R7");
        resp(1'b0, d);
        rexp_q.push_back(d);
      end
    end
    want(2'd1, 8'h00, 1'b0, ab ? (devnack ? "R9" : "R10") : "R7");
    issue(2'd1, dev, addr, alen, len, rep);
    finish_checks(ab, 1'b0, 0, tag);
  endtask

  task automatic do_write(logic [6:0] dev, logic [31:0] addr, int alen, int len,
                          bit devnack, int anack, logic [15:0] nmask, logic [7:0] seed, string tag);
    logic [6:0] fd;
    bit         ab;
    int         nf;
    fd = fold(dev, addr, alen);
    ab = devnack;
    nf = 0;
    want(2'd0, 8'h00, 1'b0, tag);
    want(2'd2, {fd, 1'b0}, 1'b0, "R8");
    resp(devnack, 8'h00);
    for (int i = alen - 1; i >= 0 && !ab; i--) begin
      want(2'd2, 8'(addr >> (8 * i)), 1'b0, "R4");
      resp(i == anack, 8'h00);
      if (i == anack) ab = 1'b1;
    end
    if (!ab) begin
      for (int k = 0; k < len; k++) begin
        logic [7:0] d;
        d = seed ^ 8'(k * 29);
        wq.push_back(d);
        want(2'd2, d, 1'b0, "R14");
        resp(nmask[k], 8'h00);
        if (nmask[k]) nf++;
      end
    end
    want(2'd1, 8'h00, 1'b0, ab ? (devnack ? "R9" : "R10") : "R11");
    issue(2'd2, dev, addr, alen, len, 1'b0);
    finish_checks(ab, 1'b0, nf, tag);
    wq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && cmd_ready && !error && !present && fail_count == 0 && !be_req && !rd_valid && !wr_ready,
        "R1", "reset outputs", {busy, cmd_ready, error, present, be_req}, 5'b01000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && cmd_ready && !be_req, "R1", "idle after reset", {busy, cmd_ready, be_req}, 3'b010);

    do_probe(2'd0, 7'h50, 1'b0);                                            // R3 present
    do_probe(2'd3, 7'h51, 1'b1);                                            // R3 absent, op 3
    do_read(7'h50, 32'h0003_1234, 2, 3, 1'b0, 1'b0, -1, 1'b0, 8'h11, "R5"); // stop+start, fold R8
    do_read(7'h54, 32'h0000_01A5, 1, 2, 1'b1, 1'b0, -1, 1'b1, 8'h40, "R12"); // repeated start, ignored NACK
    do_read(7'h20, 32'h0000_0000, 0, 4, 1'b0, 1'b0, -1, 1'b0, 8'h7E, "R6");  // no address phase
    do_read(7'h30, 32'hDEAD_BEEF, 4, 1, 1'b0, 1'b0, -1, 1'b0, 8'hC3, "R4");  // four bytes, no fold
    do_read(7'h50, 32'h0000_0777, 2, 2, 1'b0, 1'b1, -1, 1'b0, 8'h00, "R9");  // device NACK
    do_read(7'h50, 32'h0012_3456, 3, 2, 1'b1, 1'b0, 0, 1'b0, 8'h00, "R10");  // last address byte NACK
    do_read(7'h48, 32'h0000_0201, 1, 0, 1'b0, 1'b0, -1, 1'b0, 8'h00, "R7");  // zero-length read
    do_write(7'h50, 32'h0002_ABCD, 2, 5, 1'b0, -1, 16'b01010, 8'h5A, "R11"); // data NACKs counted
    do_write(7'h60, 32'h0000_0000, 0, 2, 1'b0, -1, 16'b00000, 8'h99, "R14");
    do_write(7'h62, 32'h0000_0010, 1, 3, 1'b1, -1, 16'b00000, 8'h01, "R9");
    do_write(7'h64, 32'h0000_1020, 2, 3, 1'b0, 1, 16'b00000, 8'h02, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R13 watchdog actual=running expected=idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule